// File: doc/BRIEF.md
# Dual-Clock FIFO with Preset Almost Thresholds

This block is a 64-word, 36-bit first-in first-out buffer that joins two unrelated clock domains. Words enter on the writer side, clocked by `clk_a`, and leave on the reader side, clocked by `clk_b`. Each side moves a word on a rising edge only when its active-low select is low and its active-high enable is high. The reader's output pad is modelled as a data register plus an output-enable that follows the select.

Each domain has its own status outputs, all active low. The writer side has full and almost-full. The reader side has empty and almost-empty. Full and empty are held asserted during reset. Full releases on the second writer edge after reset ends. Empty releases on the second reader edge after a word lands in an empty store. A two-bit code, captured as reset is released, picks the almost-threshold X.

Top module: `dcfifo_flags`

## Requirements
- R1: A word is written on a rising `clk_a` edge only when `a_sel_n` is 0 and `a_en` is 1. A word is read on a rising `clk_b` edge only when `b_sel_n` is 0 and `b_en` is 1. Any other combination leaves the stored contents, the flags and `b_dout` unchanged.
- R2: `full_n` is 0 while `rst_n` is 0. After release it stays 0 through the first rising `clk_a` edge and goes to 1 on the second.
- R3: `empty_n` is 0 while `rst_n` is 0. After a write into an empty store it is still 0 after the first rising `clk_b` edge that follows the write edge, and it is 1 after the second.
- R4: The store holds exactly 64 words. `full_n` is 0 once 64 words are held, and a further qualified write is dropped without changing the contents.
- R5: While `empty_n` is 0, a qualified read is blocked and `b_dout` keeps its value.
- R6: Once the pointers have settled, `aempty_n` is 0 exactly when the stored word count is less than or equal to X.
- R7: Once the pointers have settled, `afull_n` is 0 exactly when the number of free words (64 minus the count) is less than or equal to X.
- R8: `ofs_sel` is captured as reset is released and sets X. The codes 2'b00, 2'b01, 2'b10 and 2'b11 give X = 16, 12, 8 and 4.
- R9: Words leave in the order they were written. `b_dout` takes the oldest word on the `clk_b` edge of a qualified read and holds it until the next such read.
- R10: `b_oe` is 1 exactly when `b_sel_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Writer-side clock |
| clk_b | input | 1 | Reader-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| ofs_sel | input | 2 | Almost-threshold preset code, captured as reset is released |
| a_sel_n | input | 1 | Writer select, active low |
| a_en | input | 1 | Writer enable, active high |
| a_din | input | 36 | Write data |
| full_n | output | 1 | Full flag, active low, `clk_a` domain |
| afull_n | output | 1 | Almost-full flag, active low, `clk_a` domain |
| b_sel_n | input | 1 | Reader select, active low |
| b_en | input | 1 | Reader enable, active high |
| b_dout | output | 36 | Read data register |
| b_oe | output | 1 | Output enable for the read data pads |
| empty_n | output | 1 | Empty flag, active low, `clk_b` domain |
| aempty_n | output | 1 | Almost-empty flag, active low, `clk_b` domain |

## Verification
The hardest situations to reach are the exact edge on which a flag releases. A write edge has to be placed so that the next two reader edges can be counted without ambiguity. The two clock periods are chosen so their edges never coincide, and the bench checks `empty_n` right after each of the two following `clk_b` edges. It does the same for `full_n` after reset is released. The threshold boundaries are covered by filling the store one word at a time to 64 and draining it back to zero under each of the four preset codes. Every flag is compared with the value computed from the word count after each step.

// File: rtl/dcf_pkg.sv
// Shared definitions for the dual-clock FIFO.
// Assumes the depth is a power of two and a multiple of 16, so the
// threshold presets come out whole.
package dcf_pkg;

    // Threshold preset codes, from the widest margin to the tightest.
    typedef enum logic [1:0] {
        OFS_QUARTER = 2'b00,
        OFS_3_16    = 2'b01,
        OFS_EIGHTH  = 2'b10,
        OFS_16TH    = 2'b11
    } ofs_code_e;

    // Threshold X for a code: depth/4 minus code * depth/16.
    function automatic int unsigned offset_for(input ofs_code_e code,
                                               input int unsigned depth);
        int unsigned c;
        c = int'(code);
        return depth / 4 - c * (depth / 16);
    endfunction

endpackage

// File: rtl/dcf_gray_sync.sv
// Two-flop synchronizer for a Gray-coded pointer.
// Assumes the input changes at most one bit per source clock edge.
// Reset is synchronous and active low, and clears both stages.
module dcf_gray_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Move the pointer through two stages in the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcf_wr_ctl.sv
// Writer-side control in the clk_a domain.
// Keeps the write pointer and computes full and almost-full from the
// synchronized read pointer. The threshold is captured on each edge
// while reset is low, so the last captured value is the code present
// as reset is released. Full is held low for two edges after release.
module dcf_wr_ctl #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ofs_sel,
    input  logic          sel_n,
    input  logic          en,
    input  logic [AW:0]   rgray_sync,
    output logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic [AW:0]   wgray,
    output logic          full_n,
    output logic          afull_n
);
    localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

    logic [AW:0] wbin, wbin_nxt, rbin_s, used, free, x_thr;
    logic [1:0]  arm;

    // Convert the synchronized read pointer from Gray to binary.
    always_comb begin
        rbin_s[AW] = rgray_sync[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            rbin_s[i] = rbin_s[i+1] ^ rgray_sync[i];
        end
    end

    // Compute occupancy, the flags and write qualification.
    always_comb begin
        used     = wbin - rbin_s;
        free     = DEPTH_W - used;
        full_n   = arm[1] && (used != DEPTH_W);
        afull_n  = (free > x_thr);
        wr_fire  = !sel_n && en && full_n;
        wbin_nxt = wbin + (AW+1)'(1);
        wr_addr  = wbin[AW-1:0];
    end

    // Advance the write pointer, run the release delay and capture the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            arm   <= 2'b00;
            x_thr <= (AW+1)'(dcf_pkg::offset_for(dcf_pkg::ofs_code_e'(ofs_sel), DEPTH));
        end else begin
            arm <= {arm[0], 1'b1};
            if (wr_fire) begin
                wbin  <= wbin_nxt;
                wgray <= wbin_nxt ^ (wbin_nxt >> 1);
            end
        end
    end

    // A write attempted while full must not move the pointer.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !sel_n && en) |=> $stable(wgray));

    // On the first edge after release, full is still asserted.
    assert_full_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !full_n);

    // Once the release delay is over, full implies almost-full.
    assert_afull_covers_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && $past(rst_n) && $past(rst_n, 2)) |-> !afull_n);

    // The pointer crossing domains changes by at most one bit per edge.
    assert_gray_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcf_rd_ctl.sv
// Reader-side control in the clk_b domain.
// Keeps the read pointer and computes empty and almost-empty from the
// synchronized write pointer. The flags are decoded from registers
// without a further stage, so empty releases on the second clk_b edge
// after a write into an empty store.
module dcf_rd_ctl #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ofs_sel,
    input  logic          sel_n,
    input  logic          en,
    input  logic [AW:0]   wgray_sync,
    output logic          rd_fire,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   rgray,
    output logic          empty_n,
    output logic          aempty_n
);
    logic [AW:0] rbin, rbin_nxt, wbin_s, used, x_thr;

    // Convert the synchronized write pointer from Gray to binary.
    always_comb begin
        wbin_s[AW] = wgray_sync[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            wbin_s[i] = wbin_s[i+1] ^ wgray_sync[i];
        end
    end

    // Compute occupancy, the flags and read qualification.
    always_comb begin
        used     = wbin_s - rbin;
        empty_n  = (used != '0);
        aempty_n = (used > x_thr);
        rd_fire  = !sel_n && en && empty_n;
        rbin_nxt = rbin + (AW+1)'(1);
        rd_addr  = rbin[AW-1:0];
    end

    // Advance the read pointer and capture the threshold during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            x_thr <= (AW+1)'(dcf_pkg::offset_for(dcf_pkg::ofs_code_e'(ofs_sel), DEPTH));
        end else if (rd_fire) begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    // A read attempted while empty must not move the pointer.
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |=> $stable(rgray));

    // Empty is the lowest occupancy, so almost-empty must also be asserted.
    assert_empty_in_aempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);
endmodule

// File: rtl/dcf_mem.sv
// Storage array with a write port on one clock and a registered read
// port on the other. Assumes the controls never let a write and a read
// hit the same entry in the same cycle while that entry is live.
module dcf_mem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 36,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    // Write one entry on a qualified writer edge.
    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    // Load the output register on a qualified reader edge.
    always_ff @(posedge rclk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= store[raddr];
    end

    // Read data holds between qualified reads.
    assert_dout_holds_R9: assert property (@(posedge rclk) disable iff (!rst_n)
        !re |=> $stable(rdata));
endmodule

// File: rtl/dcfifo_flags.sv
// Top level of the dual-clock FIFO with active-low status flags.
// Assumes clk_a and clk_b are free-running, and that rst_n is held low
// for at least two edges of each clock. The read pads are split into a
// data register and an output enable.
module dcfifo_flags #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 36
) (
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             rst_n,
    input  logic [1:0]       ofs_sel,
    input  logic             a_sel_n,
    input  logic             a_en,
    input  logic [WIDTH-1:0] a_din,
    output logic             full_n,
    output logic             afull_n,
    input  logic             b_sel_n,
    input  logic             b_en,
    output logic [WIDTH-1:0] b_dout,
    output logic             b_oe,
    output logic             empty_n,
    output logic             aempty_n
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_fire, rd_fire;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [AW:0]   wgray, rgray, wgray_b, rgray_a;

    dcf_wr_ctl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .clk(clk_a), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .sel_n(a_sel_n), .en(a_en), .rgray_sync(rgray_a),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .wgray(wgray),
        .full_n(full_n), .afull_n(afull_n)
    );

    dcf_rd_ctl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .clk(clk_b), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .sel_n(b_sel_n), .en(b_en), .wgray_sync(wgray_b),
        .rd_fire(rd_fire), .rd_addr(rd_addr), .rgray(rgray),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    dcf_gray_sync #(.W(AW+1)) u_w2r (
        .clk(clk_b), .rst_n(rst_n), .d(wgray), .q(wgray_b)
    );

    dcf_gray_sync #(.W(AW+1)) u_r2w (
        .clk(clk_a), .rst_n(rst_n), .d(rgray), .q(rgray_a)
    );

    dcf_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_mem (
        .wclk(clk_a), .we(wr_fire), .waddr(wr_addr), .wdata(a_din),
        .rclk(clk_b), .rst_n(rst_n), .re(rd_fire), .raddr(rd_addr),
        .rdata(b_dout)
    );

    // Drive the read pads only while the reader is selected.
    always_comb b_oe = !b_sel_n;
endmodule

// File: tb/sim_dcfifo_flags.sv
`timescale 1ns/1ps
module sim_dcfifo_flags;
    logic        clk_a, clk_b, rst_n;
    logic [1:0]  ofs_sel;
    logic        a_sel_n, a_en, b_sel_n, b_en;
    logic [35:0] a_din, b_dout;
    logic        full_n, afull_n, b_oe, empty_n, aempty_n;

    int total = 0;
    int fails = 0;

    dcfifo_flags u0 (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .a_sel_n(a_sel_n), .a_en(a_en), .a_din(a_din),
        .full_n(full_n), .afull_n(afull_n),
        .b_sel_n(b_sel_n), .b_en(b_en), .b_dout(b_dout), .b_oe(b_oe),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    // clk_a rises at 5+10k (100 MHz); clk_b rises at 2+14k; the two never coincide.
    initial begin clk_a = 0; #5; forever begin clk_a = 1; #5; clk_a = 0; #5; end end
    initial begin clk_b = 0; #2; forever begin clk_b = 1; #7; clk_b = 0; #7; end end

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    function automatic logic [35:0] pat(input int code, input int idx);
        logic [31:0] v;
        v = 32'(idx) * 32'h9E3779B1 ^ 32'(code * 77 + 5);
        return {4'(code + 1), v};
    endfunction

    task automatic wr_word(input logic [35:0] d);
        @(posedge clk_a); #2;
        a_sel_n = 0; a_en = 1; a_din = d;
        @(posedge clk_a); #2;
        a_sel_n = 1; a_en = 0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk_b);
        repeat (4) @(posedge clk_a);
        #1;
    endtask

    // Compare all four flags with the values computed from the count (R6, R7, R4).
    task automatic chk_flags(input int n, input int x);
        chk("R3 empty_n", 36'(empty_n), 36'(n > 0));
        chk("R6 aempty_n", 36'(aempty_n), 36'(n > x));
        chk("R4 full_n", 36'(full_n), 36'(n < 64));
        chk("R7 afull_n", 36'(afull_n), 36'((64 - n) > x));
    endtask

    initial begin
        #1_000_000;
        total++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        rst_n = 0; ofs_sel = 0; a_sel_n = 1; a_en = 0; a_din = 0; b_sel_n = 1; b_en = 0;
        for (int code = 0; code < 4; code++) begin
            int x;
            logic [35:0] last;
            x = 16 - 4 * code;   // R8 presets
            @(posedge clk_a); #2;
            rst_n = 0; ofs_sel = 2'(code);
            repeat (4) @(posedge clk_a);
            repeat (3) @(posedge clk_b);
            @(posedge clk_a); #1;
            chk("R2 full_n in reset", 36'(full_n), 36'd0);
            chk("R3 empty_n in reset", 36'(empty_n), 36'd0);
            chk("R10 b_oe idle", 36'(b_oe), 36'd0);
            #1; rst_n = 1;
            @(posedge clk_a); #1;
            chk("R2 full_n first edge", 36'(full_n), 36'd0);
            @(posedge clk_a); #1;
            chk("R2 full_n second edge", 36'(full_n), 36'd1);
            chk("R9 b_dout after reset", b_dout, 36'd0);
            #1; ofs_sel = 2'(~code);   // changes after release must not matter (R8)

            // R1: unqualified writes leave the store empty.
            @(posedge clk_a); #2; a_sel_n = 1; a_en = 1; a_din = 36'hBAD;
            @(posedge clk_a); #2; a_sel_n = 0; a_en = 0;
            @(posedge clk_a); #2; a_sel_n = 1; a_en = 0;
            settle();
            chk("R1 no write unqualified", 36'(empty_n), 36'd0);

            // R3: exact release edge of empty_n after the first word.
            @(posedge clk_a); #2; a_sel_n = 0; a_en = 1; a_din = pat(code, 0);
            @(posedge clk_a);
            fork
                begin #2; a_sel_n = 1; a_en = 0; end
                begin
                    @(posedge clk_b); #1;
                    chk("R3 empty_n first B edge", 36'(empty_n), 36'd0);
                    @(posedge clk_b); #1;
                    chk("R3 empty_n second B edge", 36'(empty_n), 36'd1);
                end
            join
            settle();
            chk_flags(1, x);

            // Fill to capacity, checking the thresholds at every count (R6, R7, R8).
            for (int n = 2; n <= 64; n++) begin
                wr_word(pat(code, n - 1));
                settle();
                chk_flags(n, x);
            end
            // R4: a write while full is dropped.
            wr_word(36'hFFFF_FFFF_F);
            settle();
            chk("R4 full_n stays low", 36'(full_n), 36'd0);

            // R1: unqualified reads consume nothing.
            @(posedge clk_b); #2; b_sel_n = 0; b_en = 0;
            @(posedge clk_b); #1;
            chk("R10 b_oe selected", 36'(b_oe), 36'd1);
            #1; b_sel_n = 1; b_en = 1;
            @(posedge clk_b); #1;
            chk("R10 b_oe deselected", 36'(b_oe), 36'd0);
            chk("R1 b_dout no read", b_dout, 36'd0);
            #1; b_en = 0;
            settle();
            chk_flags(64, x);

            // Drain in order (R9), checking the thresholds on the way down.
            for (int n = 64; n >= 1; n--) begin
                @(posedge clk_b); #2; b_sel_n = 0; b_en = 1;
                @(posedge clk_b); #1;
                chk("R9 order", b_dout, pat(code, 64 - n));
                #1; b_sel_n = 1; b_en = 0;
                settle();
                chk_flags(n - 1, x);
            end
            last = pat(code, 63);

            // R5: a read while empty leaves b_dout unchanged.
            @(posedge clk_b); #2; b_sel_n = 0; b_en = 1;
            @(posedge clk_b); #1;
            chk("R5 b_dout held when empty", b_dout, last);
            #1; b_sel_n = 1; b_en = 0;
            settle();
            chk("R5 still empty", 36'(empty_n), 36'd0);
        end
        report();
    end
endmodule